// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits at the decode/issue point of a statically scheduled, single-issue pipeline (fetch, decode, execute, memory, writeback) whose functional units finish after different numbers of cycles. Each cycle it looks at one decoded instruction: its operation class, its destination register, two source registers, and a bit per register that picks the integer or the floating-point file. It decides whether the instruction may leave decode this cycle. When it may not, it raises `stall`, and the front end must present the same instruction again on the next cycle.

Every register in both files has two pieces of state. A ready countdown says when a consumer may enter execute with that register's value forwarded. A short writeback schedule says in which future cycles results will be written to that register. Read-after-write hazards are checked against the countdowns. Write-after-write ordering is checked against the schedules. Each cycle the schedules also drive one writeback strobe per register, and several registers may be strobed in the same cycle.

Two free-running counters record accepted instructions and stall cycles. A bench can use them to measure cycles per instruction over a loop body.

Top module: `issue_interlock`

## Requirements
- R1: After reset, no register is pending. Both writeback masks and both counters read zero, and the first instruction is accepted without a stall whatever registers it names.
- R2: An integer ALU result (class code 0) can be used as an execute-time source by the very next instruction without a stall. Its writeback strobe rises exactly 3 cycles after the issue cycle.
- R3: A load (class code 1) writes back 5 cycles after issue. An execute-time source that depends on it may issue no earlier than 4 cycles after the load, so a dependent instruction presented right behind it stalls 3 cycles.
- R4: An FP add (class code 3) writes back 5 cycles after issue. A dependent execute-time source may issue no earlier than 4 cycles after it.
- R5: For a store (class code 2), source 1 is the address and obeys the execute-time rule. Source 2 is the data and is needed only at the memory stage, so the store may issue 3 cycles after a load or FP add that produces the data. Presented directly behind that producer, it stalls 2 cycles.
- R6: While `stall` is high, the presented instruction is not accepted and nothing behind it is accepted. `issued_cnt` counts accepted instructions and `stall_cnt` counts cycles with `stall` high.
- R7: An instruction whose writeback would fall in the same cycle as, or earlier than, a writeback already scheduled to its destination stalls until it would fall later. An integer load of r3 followed at once by an ALU write of r3 stalls 2 cycles, and r3 is then strobed in two consecutive cycles.
- R8: Writebacks to different registers that fall in the same cycle, in the same file or in both files, are all strobed in that cycle. Mask bit n corresponds to register n.
- R9: Integer register 0 is never pending. Reading it never stalls, and writing it produces no strobe. FP register 0 is an ordinary register.
- R10: A branch (class code 4) writes nothing and adds no bubble, so the delay-slot instruction after it is accepted in the next cycle. A software-pipelined store/add/load/branch/increment loop runs at 5 instructions per 5 cycles in steady state. The straightforward load/add/store/branch/increment order takes 10 cycles per 5 instructions.
- R11: Only the listed sources are checked. A load checks source 1 only, an FP add, ALU or branch checks both sources, and class codes 5 to 7 check no source and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_cls | input | 3 | Operation class code |
| in_dst | input | 5 | Destination register number |
| in_dst_fp | input | 1 | Destination is in the FP file |
| in_src1 | input | 5 | First source register number |
| in_src1_fp | input | 1 | First source is in the FP file |
| in_src2 | input | 5 | Second source register number |
| in_src2_fp | input | 1 | Second source is in the FP file |
| stall | output | 1 | Presented instruction is held this cycle |
| issue | output | 1 | Presented instruction is accepted this cycle |
| wb_int | output | 32 | Integer registers written back this cycle |
| wb_fp | output | 32 | FP registers written back this cycle |
| issued_cnt | output | 32 | Accepted instruction count |
| stall_cnt | output | 32 | Stall cycle count |

## Verification
Back-to-back producer/consumer pairs for each class tell the one-cycle ALU forwarding apart from the four-cycle load and FP waits. A store placed right behind its data producer, and again three slots later, separates the memory-stage data rule from the execute-stage address rule. Overlapping writes to one register, and to different registers timed to land together, show WAW ordering apart from legal same-cycle writebacks. Two versions of the same array-increment loop, one software pipelined and one straightforward, show the zero-stall steady state against five stalls per iteration, and they also cover the branch delay slot.

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int NREG     = 32,
  parameter int MEM_CYC  = 3,
  parameter int FPEX_CYC = 4,
  parameter int CNT_W    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2:0]              in_cls,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic                    in_dst_fp,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic                    in_src1_fp,
  input  logic [$clog2(NREG)-1:0] in_src2,
  input  logic                    in_src2_fp,
  output logic                    stall,
  output logic                    issue,
  output logic [NREG-1:0]         wb_int,
  output logic [NREG-1:0]         wb_fp,
  output logic [CNT_W-1:0]        issued_cnt,
  output logic [CNT_W-1:0]        stall_cnt
);
  localparam int RW      = $clog2(NREG);
  localparam int LAT_ALU = 3;
  localparam int LAT_MEM = MEM_CYC + 2;
  localparam int LAT_FP  = FPEX_CYC + 1;
  localparam int SW      = (LAT_MEM > LAT_FP) ? LAT_MEM : LAT_FP;
  localparam int DLY_ALU = 1;
  localparam int DLY_MEM = LAT_MEM - 1;
  localparam int DLY_FP  = LAT_FP - 1;
  localparam int DMAX    = (DLY_MEM > DLY_FP) ? DLY_MEM : DLY_FP;
  localparam int TW      = $clog2(DMAX + 1);

  localparam logic [2:0] C_ALU    = 3'd0;
  localparam logic [2:0] C_LOAD   = 3'd1;
  localparam logic [2:0] C_STORE  = 3'd2;
  localparam logic [2:0] C_FPADD  = 3'd3;
  localparam logic [2:0] C_BRANCH = 3'd4;

  logic [NREG*SW-1:0] sch_i_flat, sch_f_flat;
  logic [NREG*TW-1:0] rdy_i_flat, rdy_f_flat;

  logic          use_a, use_b, late_b, writes, wr_en;
  logic [7:0]    lat;
  logic [TW-1:0] rdy_set, ra, rb;
  logic [SW-1:0] dsch, new_bit;
  logic          raw_a, raw_b, waw;

  assign use_a  = (in_cls <= C_BRANCH);
  assign use_b  = (in_cls == C_ALU) || (in_cls == C_FPADD) || (in_cls == C_BRANCH);
  assign late_b = (in_cls == C_STORE);
  assign writes = (in_cls == C_ALU) || (in_cls == C_LOAD) || (in_cls == C_FPADD);
  assign wr_en  = writes && (in_dst_fp || in_dst != '0);

  always_comb begin
    lat     = 8'(LAT_FP);
    rdy_set = TW'(DLY_FP - 1);
    if (in_cls == C_ALU) begin
      lat     = 8'(LAT_ALU);
      rdy_set = TW'(DLY_ALU - 1);
    end else if (in_cls == C_LOAD) begin
      lat     = 8'(LAT_MEM);
      rdy_set = TW'(DLY_MEM - 1);
    end
  end

  assign new_bit = SW'(1) << (lat - 8'd1);

  assign ra = in_src1_fp ? rdy_f_flat[in_src1*TW +: TW]
            : (in_src1 == '0 ? '0 : rdy_i_flat[in_src1*TW +: TW]);
  assign rb = in_src2_fp ? rdy_f_flat[in_src2*TW +: TW]
            : (in_src2 == '0 ? '0 : rdy_i_flat[in_src2*TW +: TW]);

  assign raw_a = use_a && (ra != '0);
  assign raw_b = (use_b && (rb != '0)) || (late_b && (rb > TW'(1)));

  assign dsch = in_dst_fp ? sch_f_flat[in_dst*SW +: SW] : sch_i_flat[in_dst*SW +: SW];
  assign waw  = wr_en && ((dsch >> lat) != '0);

  assign stall = in_valid && (raw_a || raw_b || waw);
  assign issue = in_valid && !stall;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit_i, hit_f;
    logic [SW-1:0] si, sf;
    logic [TW-1:0] ri, rf;

    assign hit_i = issue && wr_en && !in_dst_fp && (in_dst == RW'(g));
    assign hit_f = issue && wr_en &&  in_dst_fp && (in_dst == RW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        si <= '0;
        sf <= '0;
        ri <= '0;
        rf <= '0;
      end else begin
        si <= (si >> 1) | (hit_i ? new_bit : '0);
        sf <= (sf >> 1) | (hit_f ? new_bit : '0);
        ri <= hit_i ? rdy_set : ((ri != '0) ? ri - TW'(1) : '0);
        rf <= hit_f ? rdy_set : ((rf != '0) ? rf - TW'(1) : '0);
      end
    end

    assign sch_i_flat[g*SW +: SW] = si;
    assign sch_f_flat[g*SW +: SW] = sf;
    assign rdy_i_flat[g*TW +: TW] = ri;
    assign rdy_f_flat[g*TW +: TW] = rf;
    assign wb_int[g] = si[0];
    assign wb_fp[g]  = sf[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issued_cnt <= '0;
      stall_cnt  <= '0;
    end else begin
      if (issue) issued_cnt <= issued_cnt + CNT_W'(1);
      if (stall) stall_cnt  <= stall_cnt + CNT_W'(1);
    end
  end

  logic [1:0] age;
  logic       iss_alu_int, iss_load_fp, iss_load_int, iss_fp_fp;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign iss_alu_int  = issue && in_cls == C_ALU && !in_dst_fp && in_dst != '0;
  assign iss_load_fp  = issue && in_cls == C_LOAD && in_dst_fp;
  assign iss_load_int = issue && in_cls == C_LOAD && !in_dst_fp && in_dst != '0;
  assign iss_fp_fp    = issue && in_cls == C_FPADD && in_dst_fp;

  AST_ALU_WB_DELAY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(iss_alu_int, 3)) |-> wb_int[$past(in_dst, 3)]); // R2

  AST_LOAD_USE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(iss_load_fp) && in_valid && in_cls == C_FPADD
     && in_src1_fp && in_src1 == $past(in_dst)) |-> stall); // R3

  AST_STORE_DATA_WAIT: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(iss_fp_fp) && in_valid && in_cls == C_STORE
     && in_src2_fp && in_src2 == $past(in_dst)) |-> stall); // R5

  AST_WAW_ORDER: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(iss_load_int) && in_valid && in_cls == C_ALU
     && !in_dst_fp && in_dst == $past(in_dst)) |-> stall); // R7

  AST_ZERO_REG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wb_int[0]); // R9
endmodule

// File: tb/tb_issue_interlock.sv
`timescale 1ns/1ps
module tb_issue_interlock;
  localparam logic [2:0] ALU = 3'd0, LD = 3'd1, ST = 3'd2, FPA = 3'd3, BR = 3'd4, NOP5 = 3'd5;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_cls;
  logic [4:0]  in_dst, in_src1, in_src2;
  logic        in_dst_fp, in_src1_fp, in_src2_fp;
  logic        stall, issue;
  logic [31:0] wb_int, wb_fp, issued_cnt, stall_cnt;

  always #2.5 clk = ~clk;

  issue_interlock dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_dst_fp(in_dst_fp),
    .in_src1(in_src1), .in_src1_fp(in_src1_fp),
    .in_src2(in_src2), .in_src2_fp(in_src2_fp),
    .stall(stall), .issue(issue), .wb_int(wb_int), .wb_fp(wb_fp),
    .issued_cnt(issued_cnt), .stall_cnt(stall_cnt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  bit done = 0, mon_on = 0;
  int q_cyc[$];
  int q_reg[$];
  int t_last;
  logic [63:0] em, am;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [4:0] d, input bit dfp,
                      input logic [4:0] a, input bit afp, input logic [4:0] b, input bit bfp,
                      input int exp_st, input string req);
    int n = 0;
    int lat;
    in_valid = 1'b1; in_cls = c;
    in_dst = d; in_dst_fp = dfp;
    in_src1 = a; in_src1_fp = afp;
    in_src2 = b; in_src2_fp = bfp;
    #1;
    while (stall) begin
      n++;
      @(negedge clk);
      #1;
    end
    t_last = cyc;
    if (exp_st >= 0) chk(n == exp_st, req, "stall cycles", n, exp_st);
    lat = (c == ALU) ? 3 : 5;
    if ((c == ALU || c == LD || c == FPA) && (dfp || d != 5'd0)) begin
      q_cyc.push_back(t_last + lat);
      q_reg.push_back(dfp ? 32 + int'(d) : int'(d));
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      em = '0;
      am = {wb_fp, wb_int};
      for (int i = q_cyc.size() - 1; i >= 0; i--) begin
        if (q_cyc[i] == cyc) begin
          em[q_reg[i]] = 1'b1;
          q_cyc.delete(i);
          q_reg.delete(i);
        end else if (q_cyc[i] < cyc) begin
          chk(1'b0, "R8", "overdue writeback reg", q_reg[i], q_cyc[i]);
          q_cyc.delete(i);
          q_reg.delete(i);
        end
      end
      if (em != '0 || am != '0)
        chk(am == em, "R2 R3 R4 R8 R9", "writeback mask", longint'(am), longint'(em));
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int i0, s0, tb_br;
    rst = 1'b1; in_valid = 1'b0; in_cls = '0;
    in_dst = '0; in_dst_fp = 0; in_src1 = '0; in_src1_fp = 0; in_src2 = '0; in_src2_fp = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mon_on = 1;
    #1;
    chk(stall == 1'b0, "R1", "stall idle", stall, 0);
    chk({wb_fp, wb_int} == '0, "R1", "masks after reset", longint'({wb_fp, wb_int}), 0);
    chk(issued_cnt == 0 && stall_cnt == 0, "R1", "counters after reset", issued_cnt + stall_cnt, 0);
    @(negedge clk);

    send(ALU, 5'd1, 0, 5'd17, 1, 5'd18, 0, 0, "R1");
    send(ALU, 5'd2, 0, 5'd1, 0, 5'd1, 0, 0, "R2");

    i0 = issued_cnt; s0 = stall_cnt;
    send(LD,  5'd0, 1, 5'd1, 0, 5'd0, 0, 0, "R3");
    send(FPA, 5'd4, 1, 5'd0, 1, 5'd2, 1, 3, "R3");
    chk(issued_cnt - i0 == 2, "R6", "issued delta", issued_cnt - i0, 2);
    chk(stall_cnt - s0 == 3, "R6", "stall delta", stall_cnt - s0, 3);

    send(FPA, 5'd6, 1, 5'd4, 1, 5'd2, 1, 3, "R4");

    send(ST,  5'd0, 0, 5'd1, 0, 5'd6, 1, 2, "R5");
    send(FPA, 5'd8, 1, 5'd2, 1, 5'd2, 1, 0, "R5");
    send(ALU, 5'd5, 0, 5'd0, 0, 5'd0, 0, 0, "R5");
    send(ALU, 5'd6, 0, 5'd0, 0, 5'd0, 0, 0, "R5");
    send(ST,  5'd0, 0, 5'd1, 0, 5'd8, 1, 0, "R5");
    send(LD,  5'd9, 0, 5'd1, 0, 5'd0, 0, 0, "R5");
    send(ST,  5'd0, 0, 5'd9, 0, 5'd2, 1, 3, "R5");

    send(LD,  5'd3, 0, 5'd1, 0, 5'd0, 0, 0, "R7");
    send(ALU, 5'd3, 0, 5'd0, 0, 5'd0, 0, 2, "R7");

    send(LD,  5'd7, 0, 5'd1, 0, 5'd0, 0, 0, "R8");
    send(ALU, 5'd10, 0, 5'd0, 0, 5'd0, 0, 0, "R8");
    send(ALU, 5'd8, 0, 5'd0, 0, 5'd0, 0, 0, "R8");
    send(LD,  5'd12, 1, 5'd1, 0, 5'd0, 0, 0, "R8");
    send(ALU, 5'd11, 0, 5'd0, 0, 5'd0, 0, 0, "R8");
    send(ALU, 5'd12, 0, 5'd0, 0, 5'd0, 0, 0, "R8");

    send(LD,  5'd0, 0, 5'd1, 0, 5'd0, 0, 0, "R9");
    send(ALU, 5'd13, 0, 5'd0, 0, 5'd0, 0, 0, "R9");

    send(LD,  5'd14, 1, 5'd1, 0, 5'd0, 0, 0, "R11");
    send(LD,  5'd15, 1, 5'd1, 0, 5'd14, 1, 0, "R11");
    send(FPA, 5'd16, 1, 5'd2, 1, 5'd2, 1, 0, "R11");
    send(NOP5, 5'd20, 0, 5'd16, 1, 5'd16, 1, 0, "R11");

    send(ALU, 5'd1, 0, 5'd0, 0, 5'd0, 0, 0, "R10");
    send(LD,  5'd0, 1, 5'd1, 0, 5'd0, 0, 0, "R10");
    send(FPA, 5'd4, 1, 5'd0, 1, 5'd2, 1, 3, "R10");
    send(LD,  5'd0, 1, 5'd1, 0, 5'd0, 0, 0, "R10");
    i0 = 0; s0 = 0;
    for (int it = 0; it < 9; it++) begin
      if (it == 1) begin i0 = issued_cnt; s0 = stall_cnt; end
      send(ST,  5'd0, 0, 5'd1, 0, 5'd4, 1, (it == 0) ? 1 : 0, "R10");
      send(FPA, 5'd4, 1, 5'd0, 1, 5'd2, 1, (it == 0) ? 1 : 0, "R10");
      send(LD,  5'd0, 1, 5'd1, 0, 5'd0, 0, 0, "R10");
      send(BR,  5'd0, 0, 5'd1, 0, 5'd2, 0, 0, "R10");
      tb_br = t_last;
      send(ALU, 5'd1, 0, 5'd1, 0, 5'd0, 0, 0, "R10");
      chk(t_last == tb_br + 1, "R10", "delay slot cycle", t_last, tb_br + 1);
    end
    chk(issued_cnt - i0 == 40, "R10", "pipelined issued", issued_cnt - i0, 40);
    chk(stall_cnt - s0 == 0, "R10", "pipelined stalls", stall_cnt - s0, 0);

    for (int it = 0; it < 4; it++) begin
      i0 = issued_cnt; s0 = stall_cnt;
      send(LD,  5'd0, 1, 5'd1, 0, 5'd0, 0, 0, "R10");
      send(FPA, 5'd4, 1, 5'd0, 1, 5'd2, 1, 3, "R10");
      send(ST,  5'd0, 0, 5'd1, 0, 5'd4, 1, 2, "R10");
      send(BR,  5'd0, 0, 5'd1, 0, 5'd2, 0, 0, "R10");
      send(ALU, 5'd1, 0, 5'd1, 0, 5'd0, 0, 0, "R10");
      chk(issued_cnt - i0 == 5, "R6", "plain loop issued", issued_cnt - i0, 5);
      chk(stall_cnt - s0 == 5, "R10", "plain loop stalls", stall_cnt - s0, 5);
    end

    repeat (10) @(negedge clk);
    chk(q_cyc.size() == 0, "R8", "pending expected writebacks", q_cyc.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule